// File: doc/BRIEF.md
# Polling Bus Arbiter

This block decides which of several devices may use a shared bus, without any per-device grant wire. Every device that wants the bus raises its own request; these are combined into one common bus-request line. While that line is high and nobody owns the bus, the arbiter walks through a programmable list of device addresses and presents one address per cycle on a set of poll-address lines. Each device holds a comparator against its own fixed address (device `k` answers to address `k`). A requesting device that sees its address claims the bus, which raises BUSY and freezes the poll lines. When the owner drops its request, BUSY falls and polling carries on from the list entry after the one that matched, so service rotates through the list.

A device's priority is its position in the list, counted from the current poll position. The list is a register of `NUM_DEV` entries, each `$clog2(NUM_DEV)` bits wide. It can be rewritten through a small write port, but only while the bus is completely quiet. A list entry whose device is absent, broken or silent costs one poll cycle and is skipped. A single device may therefore be listed several times to give it a larger share.

Top module: `poll_arbiter`

## Requirements
- R1: After reset, list entry `k` holds address `k`, the poll position is entry 0, `busy` is 0 and `devOnBus` is all zeros.
- R2: `busReq` is the OR of all `devReq` bits. `pollActive` is 1 exactly when `busReq` is 1 and `busy` is 0.
- R3: `pollAddr` always shows the list entry at the current poll position. In each cycle with `pollActive` high and no match, the position moves to the next entry, and it goes from entry `NUM_DEV-1` back to entry 0.
- R4: If, during a cycle with `pollActive` high, the device whose index equals `pollAddr` has its request high, then on the next cycle `busy` is 1 and `devOnBus` is one-hot at that device's bit.
- R5: While `busy` is 1 and the owning device keeps its request high, `busy`, `devOnBus` and `pollAddr` stay unchanged, whatever the other devices request.
- R6: On the clock edge after the owning device drops its request, `busy` and `devOnBus` clear and the poll position moves to the entry after the one that matched.
- R7: A write with `cfgWrEn` high stores `cfgWrData` into entry `cfgWrIdx` only when all `devReq` bits are 0 and `busy` is 0. At any other time the write leaves the list unchanged.
- R8: When several devices request at once, the winner is the first one whose address appears in the list at or after the current poll position, with wraparound.
- R9: A list entry whose device is not requesting takes exactly one poll cycle and never stops polling.
- R10: With no request and no owner, the poll position holds and `pollActive` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| devReq | input | NUM_DEV | Per-device bus request, bit k for device address k |
| cfgWrEn | input | 1 | Write strobe for the polling list |
| cfgWrIdx | input | ADDR_W | List entry to write |
| cfgWrData | input | ADDR_W | Device address to store |
| busReq | output | 1 | Common bus-request line (OR of requests) |
| pollActive | output | 1 | Arbiter is stepping the poll lines this cycle |
| pollAddr | output | ADDR_W | Address currently on the poll lines |
| busy | output | 1 | Bus is owned by a device |
| devOnBus | output | NUM_DEV | One-hot owner indication, all zero when free |

## Verification
On every cycle, the assertions check that ownership is one-hot exactly while `busy` is high, that a polled requester takes the bus on the next edge, that a polled non-requester never does, that the poll lines and the owner freeze while the owner keeps requesting, and that a dropped request frees the bus. The rotation order, the wraparound, priority by list position, the effect of a rewritten list and the rejection of writes made during traffic depend on the stored list. Only the bench shows these, by comparing against its reference model under directed and random request patterns.

// File: rtl/poll_arb_pkg.sv
package poll_arb_pkg;
  typedef struct packed {
    logic advance;   // step to next list entry
    logic claim;     // latch polled address as bus owner
    logic release_;  // owner gave up the bus
    logic cfgWrite;  // accepted list write
  } ctrlStrobe_t;
endpackage

// File: rtl/poll_arb_ctrl.sv
module poll_arb_ctrl
  import poll_arb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        anyReq,
  input  logic        hit,
  input  logic        ownerReq,
  input  logic        cfgWrEn,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        pollActive
);
  logic busyQ;

  always_comb begin
    pollActive      = anyReq && !busyQ;
    strobe.claim    = pollActive && hit;
    strobe.release_ = busyQ && !ownerReq;
    strobe.advance  = (pollActive && !hit) || strobe.release_;
    strobe.cfgWrite = cfgWrEn && !anyReq && !busyQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
    end else if (strobe.claim) begin
      busyQ <= 1'b1;
    end else if (strobe.release_) begin
      busyQ <= 1'b0;
    end
  end

  assign busy = busyQ;
endmodule

// File: rtl/poll_arb_datapath.sv
module poll_arb_datapath
  import poll_arb_pkg::*;
#(
  parameter int NUM_DEV = 4,
  localparam int ADDR_W = $clog2(NUM_DEV)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_DEV-1:0] devReq,
  input  ctrlStrobe_t        strobe,
  input  logic               busy,
  input  logic [ADDR_W-1:0]  cfgWrIdx,
  input  logic [ADDR_W-1:0]  cfgWrData,
  output logic [ADDR_W-1:0]  pollAddr,
  output logic               hit,
  output logic               ownerReq,
  output logic [NUM_DEV-1:0] devOnBus
);
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_DEV - 1);

  logic [ADDR_W-1:0] seqQ [NUM_DEV];
  logic [ADDR_W-1:0] seqIdxQ;
  logic [ADDR_W-1:0] ownerQ;
  logic [NUM_DEV-1:0] hitVec;
  logic [NUM_DEV-1:0] ownVec;

  assign pollAddr = seqQ[seqIdxQ];

  // one address comparator per device
  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    assign hitVec[d] = devReq[d] && (pollAddr == ADDR_W'(d));
    assign ownVec[d] = busy && (ownerQ == ADDR_W'(d));
  end

  assign hit      = |hitVec;
  assign devOnBus = ownVec;
  assign ownerReq = |(ownVec & devReq);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqIdxQ <= '0;
      ownerQ  <= '0;
      for (int k = 0; k < NUM_DEV; k++) seqQ[k] <= ADDR_W'(k);
    end else begin
      if (strobe.advance) seqIdxQ <= (seqIdxQ == LAST_IDX) ? '0 : seqIdxQ + 1'b1;
      if (strobe.claim) ownerQ <= pollAddr;
      if (strobe.cfgWrite) seqQ[cfgWrIdx] <= cfgWrData;
    end
  end
endmodule

// File: rtl/poll_arbiter.sv
module poll_arbiter
  import poll_arb_pkg::*;
#(
  parameter int NUM_DEV = 4,
  localparam int ADDR_W = $clog2(NUM_DEV)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_DEV-1:0] devReq,
  input  logic               cfgWrEn,
  input  logic [ADDR_W-1:0]  cfgWrIdx,
  input  logic [ADDR_W-1:0]  cfgWrData,
  output logic               busReq,
  output logic               pollActive,
  output logic [ADDR_W-1:0]  pollAddr,
  output logic               busy,
  output logic [NUM_DEV-1:0] devOnBus
);
  ctrlStrobe_t strobe;
  logic hit;
  logic ownerReq;

  assign busReq = |devReq;

  poll_arb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .anyReq(busReq), .hit(hit), .ownerReq(ownerReq),
    .cfgWrEn(cfgWrEn), .strobe(strobe), .busy(busy), .pollActive(pollActive)
  );

  poll_arb_datapath #(.NUM_DEV(NUM_DEV)) u_dp (
    .clk(clk), .rstN(rstN), .devReq(devReq), .strobe(strobe), .busy(busy),
    .cfgWrIdx(cfgWrIdx), .cfgWrData(cfgWrData), .pollAddr(pollAddr),
    .hit(hit), .ownerReq(ownerReq), .devOnBus(devOnBus)
  );
endmodule

// File: rtl/poll_arbiter_chk.sv
module poll_arbiter_chk #(
  parameter int NUM_DEV = 4,
  localparam int ADDR_W = $clog2(NUM_DEV)
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_DEV-1:0] devReq,
  input logic               pollActive,
  input logic [ADDR_W-1:0]  pollAddr,
  input logic               busy,
  input logic [NUM_DEV-1:0] devOnBus
);
  logic polledReq;
  always_comb begin
    polledReq = 1'b0;
    for (int i = 0; i < NUM_DEV; i++)
      if (devReq[i] && pollAddr == ADDR_W'(i)) polledReq = 1'b1;
  end

  // R4: one owner exactly while busy
  assert_onehot_owner_R4: assert property (@(posedge clk) disable iff (!rstN)
    $countones(devOnBus) == (busy ? 1 : 0));

  // R4: polled requester takes the bus next cycle
  assert_claim_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pollActive && polledReq) |=> (busy && devOnBus == (NUM_DEV'(1) << $past(pollAddr))));

  // R9: polled non-requester does not stop polling
  assert_skip_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pollActive && !polledReq) |=> !busy);

  // R5: owner keeps requesting, everything frozen
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && |(devOnBus & devReq)) |=> (busy && $stable(pollAddr) && $stable(devOnBus)));

  // R6: dropped request frees the bus
  assert_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(|(devOnBus & devReq))) |=> (!busy && devOnBus == '0));
endmodule

bind poll_arbiter poll_arbiter_chk #(.NUM_DEV(NUM_DEV)) u_chk (
  .clk(clk), .rstN(rstN), .devReq(devReq), .pollActive(pollActive),
  .pollAddr(pollAddr), .busy(busy), .devOnBus(devOnBus)
);

// File: tb/test_poll_arbiter.sv
module test_poll_arbiter;
  localparam int N = 4;
  localparam int AW = 2;

  logic clk = 0;
  logic rstN = 0;
  logic [N-1:0] devReq = '0;
  logic cfgWrEn = 0;
  logic [AW-1:0] cfgWrIdx = '0, cfgWrData = '0;
  logic busReq, pollActive, busy;
  logic [AW-1:0] pollAddr;
  logic [N-1:0] devOnBus;

  always #10 clk = ~clk;  // 50 MHz

  poll_arbiter #(.NUM_DEV(N)) i_poll_arbiter (
    .clk(clk), .rstN(rstN), .devReq(devReq), .cfgWrEn(cfgWrEn),
    .cfgWrIdx(cfgWrIdx), .cfgWrData(cfgWrData), .busReq(busReq),
    .pollActive(pollActive), .pollAddr(pollAddr), .busy(busy), .devOnBus(devOnBus)
  );

  int nVec = 0, nBad = 0;
  string tag = "R1";

  // reference model state
  int mSeq[N];
  int mIdx, mOwner;
  bit mBusy;

  task automatic chk(string field, int act, int exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, field, act, exp);
    end
  endtask

  task automatic step(logic [N-1:0] req, bit we = 0, int wi = 0, int wd = 0);
    bit anyReq, polling;
    @(negedge clk);
    devReq = req; cfgWrEn = we; cfgWrIdx = AW'(wi); cfgWrData = AW'(wd);
    #1;
    anyReq = |req;
    polling = anyReq && !mBusy;
    chk("busReq(R2)", busReq, anyReq);
    chk("pollActive(R2)", pollActive, polling);
    chk("pollAddr(R3)", pollAddr, mSeq[mIdx]);
    chk("busy(R4)", busy, mBusy);
    chk("devOnBus(R4)", devOnBus, mBusy ? (1 << mOwner) : 0);
    @(posedge clk);
    if (we && !anyReq && !mBusy) mSeq[wi] = wd;
    if (mBusy) begin
      if (!req[mOwner]) begin mBusy = 0; mIdx = (mIdx + 1) % N; end
    end else if (polling) begin
      if (req[mSeq[mIdx]]) begin mBusy = 1; mOwner = mSeq[mIdx]; end
      else mIdx = (mIdx + 1) % N;
    end
  endtask

  initial begin
    #2_000_000;
    nBad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    logic [N-1:0] r;
    for (int k = 0; k < N; k++) mSeq[k] = k;
    mIdx = 0; mOwner = 0; mBusy = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;

    tag = "R1"; step('0);
    tag = "R10"; repeat (3) step('0);
    // default order, device 2 alone: polls 0,1 then claims at 2 (R9)
    tag = "R9"; repeat (3) step(4'b0100);
    tag = "R5"; repeat (4) step(4'b1111);
    tag = "R6"; step(4'b0000); step(4'b0000);
    // rewrite list to 3,1,0,2 while quiet
    tag = "R7";
    step('0, 1, 0, 3); step('0, 1, 1, 1); step('0, 1, 2, 0); step('0, 1, 3, 2);
    // all request: winner decided by list position from current index
    tag = "R8"; repeat (3) step(4'b1111);
    step(4'b0000); repeat (3) step(4'b1111); step(4'b0000);
    // write attempts during traffic are ignored
    tag = "R7"; step(4'b0010, 1, 0, 0); repeat (4) step(4'b0010, 1, 1, 3);
    step('0);
    // wraparound: only device 3 (entry 0) requests
    tag = "R3"; repeat (6) step(4'b1000); step('0);
    // random traffic and occasional quiet writes
    tag = "R8";
    r = '0;
    for (int c = 0; c < 3000; c++) begin
      if ($urandom_range(0, 3) == 0) r = N'($urandom);
      if (r == 0 && $urandom_range(0, 1) == 1)
        step(r, 1, $urandom_range(0, N - 1), $urandom_range(0, N - 1));
      else
        step(r);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule